// File: doc/BRIEF.md
# Asynchronous Handshake Register Slave

This block sits on an asynchronous, acknowledge-terminated 16-bit host bus. The host addresses 16-bit words through a 13-bit word address, so each word sits at an even byte offset. Each access is qualified by an active-low select and a direction line. The block answers every access by pulling an active-low transfer acknowledge. The host holds select, direction, address and write data stable until it sees the acknowledge, then lifts select. The block lifts the acknowledge once it sees select high again. Select, direction and the interrupt-acknowledge input come from another clock domain, so the block passes them through a two-flop synchronizer. Address and write data are sampled directly, because the host keeps them stable throughout a selected access.

The block holds three registers: an interrupt enable mask, an interrupt status word and an interrupt vector. Single-cycle event pulses from neighbouring logic set the status bits. The active-low interrupt line is low while any status bit is set and also enabled. Reading the status word returns the set bits and clears them in the same step, which releases the interrupt. An interrupt-acknowledge cycle returns the vector. The read-data path is a separate output with an output-enable, and the pad ring builds the tri-state driver from the two. The bus is a strobe handshake with no valid/ready stage: the acknowledge is the only flow control, and the host cannot be back-pressured except by delaying that acknowledge.

Top module: `async_bus_regslave`

## Requirements
- R1: After reset, dtack_n and irq_n are 1 and data_oe is 0, and the enable, status and vector registers all read as 0.
- R2: A write (cs_n low, rw low) stores data_i into the addressed register. dtack_n goes low on the 4th rising clock edge after cs_n falls, and data_oe stays 0.
- R3: On a read (cs_n low, rw high), data_oe rises on the 3rd rising edge after cs_n falls and dtack_n falls on the 4th. data_o holds the register value while dtack_n is low.
- R4: dtack_n returns to 1 and data_oe to 0 on the 3rd rising edge after the host raises cs_n (or iack_n).
- R5: Each select assertion makes exactly one access. While cs_n stays low after the acknowledge, nothing is read, written or cleared again.
- R6: The interrupt enable register is at word address 0x12C2 (byte 0x2584). All 16 bits can be read and written.
- R7: The interrupt status register is at word address 0x12C3 (byte 0x2586). A 1 on bit i of evt_i at a clock edge sets bit i. Host writes to it have no effect.
- R8: A read of the status register returns the bits set before the read and clears exactly those bits. An event arriving on the same clock edge as the read stays set.
- R9: irq_n is 0 exactly when some status bit and its matching enable bit are both 1. It goes high after a status read clears every enabled bit.
- R10: The vector register is at word address 0x12C4 (byte 0x2588) and can be read and written. An acknowledge cycle (iack_n low with cs_n high) returns the vector with the same timing as R3 and R4. It writes nothing and leaves the status register alone.
- R11: Any other word address reads as 0. Writes to it are acknowledged and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Bus select, active low, asynchronous |
| rw | input | 1 | Direction: 1 read, 0 write |
| iack_n | input | 1 | Interrupt-acknowledge cycle, active low |
| addr | input | 13 | Word address (byte address bits 13:1) |
| data_i | input | 16 | Write data from the host |
| data_o | output | 16 | Read data toward the pad driver |
| data_oe | output | 1 | Enables the read-data pad driver |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| evt_i | input | 16 | Event pulses, one per status bit |

## Verification
Suppose a status bit was set or cleared wrongly. The interrupt line shows it at the clock edge that did the damage, and the next status read shows it too: the value comes back wrong, or a lost same-edge event never returns. A handshake state machine stuck or out of step shows as an acknowledge that misses the fourth-edge window, or one that never releases. The bench checks for that on every access. If the output-enable were wrong, it would show during the single cycle before the acknowledge falls, which is where the bench samples it.

// File: rtl/abrs_pkg.sv
package abrs_pkg;
  // Handshake sequencer states
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,  // waiting for a select
    ACC_LATCH = 2'd1,  // register action done, acknowledge next
    ACC_HOLD  = 2'd2   // acknowledge low until the select is released
  } acc_state_e;
endpackage

// File: rtl/abrs_sync.sv
module abrs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  // Idle level of every synchronized strobe is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '1;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/abrs_access_fsm.sv
module abrs_access_fsm
  import abrs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic rw_s,
  input  logic iack_s,
  output logic rd_stb,
  output logic wr_stb,
  output logic vec_cyc,
  output logic dtack_n,
  output logic data_oe
);
  acc_state_e state;
  logic sel_cs, sel_ia;

  always_comb begin
    sel_cs  = (state == ACC_IDLE) && !cs_s;
    sel_ia  = (state == ACC_IDLE) && cs_s && !iack_s;
    rd_stb  = (sel_cs && rw_s) || sel_ia;
    wr_stb  = sel_cs && !rw_s;
    vec_cyc = sel_ia;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ACC_IDLE;
      dtack_n <= 1'b1;
      data_oe <= 1'b0;
    end else begin
      unique case (state)
        ACC_IDLE: begin
          if (rd_stb || wr_stb) begin
            data_oe <= rd_stb;
            state   <= ACC_LATCH;
          end
        end
        ACC_LATCH: begin
          dtack_n <= 1'b0;
          state   <= ACC_HOLD;
        end
        ACC_HOLD: begin
          if (cs_s && iack_s) begin
            dtack_n <= 1'b1;
            data_oe <= 1'b0;
            state   <= ACC_IDLE;
          end
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abrs_reg_bank.sv
module abrs_reg_bank #(
  parameter int              DATA_W    = 16,
  parameter int              ADDR_W    = 13,
  parameter logic [ADDR_W-1:0] IE_WADDR  = 13'h12C2,
  parameter logic [ADDR_W-1:0] ST_WADDR  = 13'h12C3,
  parameter logic [ADDR_W-1:0] VEC_WADDR = 13'h12C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              vec_cyc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evt_i,
  output logic [DATA_W-1:0] rdata_q,
  output logic [DATA_W-1:0] st_q,
  output logic              st_clr,
  output logic              irq_n
);
  logic [DATA_W-1:0] ie_q, vec_q, rd_mux;

  assign st_clr = rd_stb && !vec_cyc && (addr == ST_WADDR);

  always_comb begin
    if (vec_cyc) rd_mux = vec_q;
    else begin
      unique case (addr)
        IE_WADDR:  rd_mux = ie_q;
        ST_WADDR:  rd_mux = st_q;
        VEC_WADDR: rd_mux = vec_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= '0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_stb && addr == IE_WADDR)  ie_q  <= wdata;
      if (wr_stb && addr == VEC_WADDR) vec_q <= wdata;
      if (rd_stb)                      rdata_q <= rd_mux;
    end
  end

  // One sticky flag per event line; a read clears, a same-edge event wins
  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= (st_q[i] && !st_clr) || evt_i[i];
    end
  end

  assign irq_n = ~|(st_q & ie_q);
endmodule

// File: rtl/async_bus_regslave.sv
module async_bus_regslave #(
  parameter int          DATA_W      = 16,
  parameter int          ADDR_W      = 13,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] IE_BADDR    = 16'h2584,
  parameter logic [15:0] ST_BADDR    = 16'h2586,
  parameter logic [15:0] VEC_BADDR   = 16'h2588
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              iack_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe,
  output logic              dtack_n,
  output logic              irq_n,
  input  logic [DATA_W-1:0] evt_i
);
  localparam logic [ADDR_W-1:0] IE_WADDR  = IE_BADDR[ADDR_W:1];
  localparam logic [ADDR_W-1:0] ST_WADDR  = ST_BADDR[ADDR_W:1];
  localparam logic [ADDR_W-1:0] VEC_WADDR = VEC_BADDR[ADDR_W:1];

  logic cs_s, rw_s, iack_s;
  logic rd_stb, wr_stb, vec_cyc, st_clr;
  logic [DATA_W-1:0] st_q;

  abrs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, rw, iack_n}),
    .q({cs_s, rw_s, iack_s})
  );

  abrs_access_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .rw_s(rw_s), .iack_s(iack_s),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .vec_cyc(vec_cyc),
    .dtack_n(dtack_n), .data_oe(data_oe)
  );

  abrs_reg_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IE_WADDR(IE_WADDR), .ST_WADDR(ST_WADDR), .VEC_WADDR(VEC_WADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .vec_cyc(vec_cyc),
    .addr(addr), .wdata(data_i), .evt_i(evt_i),
    .rdata_q(data_o), .st_q(st_q), .st_clr(st_clr), .irq_n(irq_n)
  );
endmodule

// File: rtl/abrs_chk.sv
module abrs_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dtack_n,
  input logic              data_oe,
  input logic              irq_n,
  input logic [DATA_W-1:0] evt_i,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              st_clr,
  input logic [DATA_W-1:0] st_q
);
  // R2
  ack_after_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(rd_stb || wr_stb, 2));

  // R3
  oe_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> data_oe);

  // R4
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack_n) |-> !data_oe);

  // R5
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));

  // R8
  clear_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st_q) & ~st_q)) |-> $past(st_clr));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(|evt_i) || $past(wr_stb)));
endmodule

bind async_bus_regslave abrs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dtack_n(dtack_n), .data_oe(data_oe),
  .irq_n(irq_n), .evt_i(evt_i), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .st_clr(st_clr), .st_q(st_q)
);

// File: tb/async_bus_regslave_tb.sv
module async_bus_regslave_tb;
  localparam logic [12:0] A_IE  = 13'h12C2;
  localparam logic [12:0] A_ST  = 13'h12C3;
  localparam logic [12:0] A_VEC = 13'h12C4;

  logic clk = 1'b0;
  logic rst_n, cs_n, rw, iack_n;
  logic [12:0] addr;
  logic [15:0] data_i, data_o, evt_i;
  logic data_oe, dtack_n, irq_n;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ie = '0, m_st = '0, m_vec = '0;

  always #4 clk = ~clk;

  async_bus_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .iack_n(iack_n),
    .addr(addr), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .dtack_n(dtack_n), .irq_n(irq_n), .evt_i(evt_i)
  );

  function automatic logic exp_irq_n(input logic [15:0] st, input logic [15:0] ie);
    return ~|(st & ie);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [12:0] a);
    if (a == A_IE)  return m_ie;
    if (a == A_ST)  return m_st;
    if (a == A_VEC) return m_vec;
    return 16'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // One bus access. inj is an event pulse timed onto the action edge;
  // hold_evt is pulsed while select is still held after the acknowledge.
  task automatic access(input bit rd, input bit vec, input logic [12:0] a,
                        input logic [15:0] wd, input logic [15:0] inj,
                        input logic [15:0] hold_evt, input string req,
                        output logic [15:0] rdv);
    int lat;
    bit oe_before;
    bit drive;
    drive = rd || vec;
    @(negedge clk);
    addr = a; data_i = wd; rw = drive;
    if (vec) iack_n = 1'b0; else cs_n = 1'b0;
    lat = 0; oe_before = 1'b0;
    while (dtack_n && lat < 20) begin
      @(posedge clk); #1; lat++;
      if (lat == 2) evt_i = inj;
      if (lat == 3) begin evt_i = '0; oe_before = data_oe; end
    end
    chk(lat == 4, {req, " ack latency"}, lat, 4);
    chk(oe_before == drive, {req, " oe before ack"}, oe_before, drive);
    chk(data_oe == drive, {req, " oe during ack"}, data_oe, drive);
    rdv = data_o;
    if (hold_evt != 0) begin
      evt_i = hold_evt; @(posedge clk); #1; evt_i = '0;
      @(posedge clk); #1;
    end
    @(negedge clk);
    cs_n = 1'b1; iack_n = 1'b1;
    lat = 0;
    while (!dtack_n && lat < 20) begin
      @(posedge clk); #1; lat++;
    end
    chk(lat == 3, "R4 release latency", lat, 3);
    chk(data_oe == 1'b0, "R4 oe released", data_oe, 0);
  endtask

  task automatic do_write(input logic [12:0] a, input logic [15:0] wd, input logic [15:0] inj, input string req);
    logic [15:0] dummy;
    access(1'b0, 1'b0, a, wd, inj, 16'h0, req, dummy);
    if (a == A_IE)  m_ie  = wd;
    if (a == A_VEC) m_vec = wd;
    m_st |= inj;
  endtask

  task automatic do_read(input logic [12:0] a, input logic [15:0] inj, input logic [15:0] hold_evt, input string req);
    logic [15:0] got, exp;
    exp = exp_rd(a);
    access(1'b1, 1'b0, a, 16'h0, inj, hold_evt, req, got);
    chk(got == exp, {req, " read data"}, got, exp);
    if (a == A_ST) m_st = inj; else m_st |= inj;
    m_st |= hold_evt;
  endtask

  task automatic do_iack(input logic [15:0] inj);
    logic [15:0] got;
    access(1'b0, 1'b1, 13'h0, 16'h0, inj, 16'h0, "R10 iack", got);
    chk(got == m_vec, "R10 vector", got, m_vec);
    m_st |= inj;
  endtask

  task automatic pulse_evt(input logic [15:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
    m_st |= e;
  endtask

  task automatic chk_irq(input string req);
    chk(irq_n == exp_irq_n(m_st, m_ie), {req, " irq"}, irq_n, exp_irq_n(m_st, m_ie));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [12:0] ua;
    void'($urandom(32'd2584));
    rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; iack_n = 1'b1;
    addr = '0; data_i = '0; evt_i = '0;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(dtack_n == 1'b1, "R1 dtack_n", dtack_n, 1);
    chk(data_oe == 1'b0, "R1 data_oe", data_oe, 0);
    chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    @(negedge clk); rst_n = 1'b1;
    do_read(A_IE, 0, 0, "R1");
    do_read(A_ST, 0, 0, "R1");
    do_read(A_VEC, 0, 0, "R1");

    // R6 enable register
    do_write(A_IE, 16'hFFFF, 0, "R2");
    do_read(A_IE, 0, 0, "R6");
    do_write(A_IE, 16'h00F0, 0, "R2");
    do_read(A_IE, 0, 0, "R6");

    // R7 status ignores writes, set by events
    do_write(A_ST, 16'hFFFF, 0, "R7");
    do_read(A_ST, 0, 0, "R7");
    pulse_evt(16'h0001);
    chk_irq("R9 masked event");
    pulse_evt(16'h0010);
    chk_irq("R9 enabled event");
    chk(irq_n == 1'b0, "R9 irq low", irq_n, 0);
    do_write(A_ST, 16'h0000, 0, "R7");
    do_read(A_ST, 0, 0, "R8");
    chk_irq("R9 after clear");
    chk(irq_n == 1'b1, "R9 released", irq_n, 1);
    do_read(A_ST, 0, 0, "R8");

    // R8 event on the clearing edge survives
    pulse_evt(16'h0002);
    do_read(A_ST, 16'h0020, 0, "R8");
    chk_irq("R8 same-edge event");
    // R5 event during a held select is not cleared again
    do_read(A_ST, 0, 16'h0040, "R5");
    do_read(A_ST, 0, 0, "R5");
    chk_irq("R5");

    // R10 vector register and acknowledge cycle
    do_write(A_VEC, 16'hABCD, 0, "R10");
    do_read(A_VEC, 0, 0, "R10");
    pulse_evt(16'h0080);
    do_iack(0);
    do_read(A_ST, 0, 0, "R10 status kept");

    // R11 unmapped space
    do_write(13'h0000, 16'h1234, 0, "R11");
    do_read(13'h0000, 0, 0, "R11");
    do_write(13'h12C5, 16'h5555, 0, "R11");
    do_read(13'h1FFF, 0, 0, "R11");
    do_read(A_IE, 0, 0, "R11 ie kept");
    do_read(A_VEC, 0, 0, "R11 vec kept");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [15:0] inj, r;
      int op;
      op = $urandom % 9;
      r = 16'($urandom);
      inj = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
      do begin ua = 13'($urandom); end while (ua == A_IE || ua == A_ST || ua == A_VEC);
      case (op)
        0: do_write(A_IE, r, inj, "R6");
        1: do_write(A_VEC, r, inj, "R10");
        2: do_write(A_ST, r, inj, "R7");
        3: do_write(ua, r, inj, "R11");
        4: do_read(A_IE, inj, 0, "R6");
        5: do_read(A_ST, inj, 0, "R8");
        6: do_read(ua, inj, 0, "R11");
        7: do_iack(inj);
        default: pulse_evt(r & 16'($urandom));
      endcase
      chk_irq("R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule